// File: doc/BRIEF.md
# Compare and Byte-Match Condition Unit

This purely combinational unit weighs two 64-bit operands against each other and reduces the outcome to a 4-bit condition nibble. The nibble is meant for one of eight condition fields in a wider condition register. Next to the nibble it emits a one-hot mask of eight lines, decoded from a 3-bit field index, so that the owner of the condition register knows which field to update. The unit neither holds the register nor decodes instructions.

Three kinds of operation are offered. There is a two's-complement compare and an unsigned compare. Either one can work on the full 64 bits or on the low 32 bits only. The second operand can be replaced by a 16-bit immediate. The third kind is a byte-membership test: it asks whether the lowest byte of the first operand occurs anywhere among the eight bytes of the second. For the two compares, the sticky summary-overflow flag is carried into the lowest bit of the nibble.

Top module: `cmpu_cond_unit`

## Requirements
- R1: The nibble uses bit 3 (value 8) for less-than, bit 2 (value 4) for greater-than, bit 1 (value 2) for equal and bit 0 (value 1) for summary overflow.
- R2: With `mode` = 2'b00 and `wide` = 1, the operands are compared as 64-bit two's-complement numbers. For example, 0xFFFFFFFFAAAAAAAA is less than 0x00000000AAAAAAAA.
- R3: With `mode` = 2'b01, both operands are compared as unsigned numbers.
- R4: With `wide` = 0, a compare looks only at bits 31:0 of each operand. Those bits are sign-extended for the signed compare and zero-extended for the unsigned compare, and bits 63:32 have no effect.
- R5: With `use_imm` = 1, a compare takes `imm_val` in place of `op_b`. The immediate is sign-extended to 64 bits for the signed compare and zero-extended for the unsigned compare, and the length rule of R4 then applies as usual.
- R6: With `mode[1]` = 1 (2'b10 or 2'b11), the unit runs the byte-membership test. The nibble is 4 when `op_a[7:0]` equals any of the eight bytes of `op_b`, and 0 otherwise. In this mode `wide`, `use_imm` and `imm_val` have no effect.
- R7: For a compare, bit 0 of the nibble equals `so_in`. In the byte-membership test, bit 0 is 0 whatever the value of `so_in`.
- R8: For every compare, exactly one of less-than, greater-than and equal is set.
- R9: `field_mask` has exactly one bit set, namely bit `field_sel` (bit i stands for field i), in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand; its low byte is the probe for the byte test |
| op_b | input | 64 | Second operand, or the eight bytes searched by the byte test |
| imm_val | input | 16 | Immediate value that can take the place of `op_b` |
| use_imm | input | 1 | 1 selects the immediate as the second compare operand |
| mode | input | 2 | 00 signed compare, 01 unsigned compare, 1x byte test |
| wide | input | 1 | 1 compares 64 bits, 0 compares bits 31:0 only |
| so_in | input | 1 | Sticky summary-overflow flag |
| field_sel | input | 3 | Index of the target condition field |
| cond_out | output | 4 | Condition nibble: LT, GT, EQ, SO from bit 3 down to bit 0 |
| field_mask | output | 8 | One-hot select of the target field |

## Verification
The embedded checks are immediate and combinational. They only evaluate once every input is a known 0 or 1, so undriven or X inputs at time zero never trip them. They also assume the inputs have settled. The bench meets both conditions by driving every input from time zero, changing inputs only on the falling clock edge, and sampling two nanoseconds later. The sweeps work through a fixed set of corner operands at half-word and full-word boundaries in every combination of mode, length, immediate select and overflow flag. They also cover all 256 probe bytes against several byte patterns.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;

  // Bit positions inside the condition nibble
  localparam int NIB_LT = 3;
  localparam int NIB_GT = 2;
  localparam int NIB_EQ = 1;
  localparam int NIB_SO = 0;
  localparam int NIB_W  = 4;

  typedef enum logic [1:0] {
    MODE_SIGNED  = 2'b00,
    MODE_LOGICAL = 2'b01,
    MODE_BYTE    = 2'b10,
    MODE_BYTE_X  = 2'b11
  } cmp_mode_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_nib_t;

  function automatic logic mode_is_byte(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_signed(input logic [1:0] m);
    return (m == MODE_SIGNED);
  endfunction

endpackage

// File: rtl/cmpu_operand.sv
module cmpu_operand #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              is_signed,
  input  logic              wide,
  output logic [DATA_W-1:0] ext
);

  localparam int IMM_PAD  = DATA_W - IMM_W;
  localparam int HALF_PAD = DATA_W - HALF_W;

  function automatic logic [DATA_W-1:0] widen_imm(input logic [IMM_W-1:0] v,
                                                  input logic sgn);
    return {{IMM_PAD{sgn & v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] narrow(input logic [DATA_W-1:0] v,
                                               input logic sgn);
    return {{HALF_PAD{sgn & v[HALF_W-1]}}, v[HALF_W-1:0]};
  endfunction

  logic [DATA_W-1:0] picked;

  always_comb begin
    picked = use_imm ? widen_imm(imm, is_signed) : raw;
    ext    = wide ? picked : narrow(picked, is_signed);
  end

endmodule

// File: rtl/cmpu_relate.sv
module cmpu_relate #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_signed,
  output logic              lt,
  output logic              gt,
  output logic              eq
);

  // Flipping the sign bit maps two's-complement order onto unsigned order
  function automatic logic [DATA_W-1:0] bias(input logic [DATA_W-1:0] v,
                                             input logic sgn);
    return {v[DATA_W-1] ^ sgn, v[DATA_W-2:0]};
  endfunction

  logic [DATA_W-1:0] ba, bb;

  always_comb begin
    ba = bias(a, is_signed);
    bb = bias(b, is_signed);
    eq = (a == b);
    lt = (ba < bb);
    gt = !eq && !lt;
  end

  always_comb begin
    if (!$isunknown({a, b})) begin
      a_r2_equal_operands: assert (!(a == b) || (eq && !lt && !gt))
        else $error("equal operands did not report equal");
    end
  end

endmodule

// File: rtl/cmpu_bytematch.sv
module cmpu_bytematch #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] probe,
  input  logic [DATA_W-1:0] pool,
  output logic              hit
);

  localparam int LANES = DATA_W / BYTE_W;

  logic [LANES-1:0] lane_hit;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_hit[i] = (pool[i*BYTE_W +: BYTE_W] == probe);
  end

  assign hit = |lane_hit;

  always_comb begin
    if (!$isunknown({probe, pool})) begin
      a_r6_lane0_hit: assert (!(pool[BYTE_W-1:0] == probe) || hit)
        else $error("matching byte in lane 0 missed");
    end
  end

endmodule

// File: rtl/cmpu_cond_unit.sv
module cmpu_cond_unit
  import cmpu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int IMM_W   = 16,
  parameter int FIELDS  = 8,
  parameter int FIELD_W = $clog2(FIELDS)
) (
  input  logic [DATA_W-1:0]  op_a,
  input  logic [DATA_W-1:0]  op_b,
  input  logic [IMM_W-1:0]   imm_val,
  input  logic               use_imm,
  input  logic [1:0]         mode,
  input  logic               wide,
  input  logic               so_in,
  input  logic [FIELD_W-1:0] field_sel,
  output logic [NIB_W-1:0]   cond_out,
  output logic [FIELDS-1:0]  field_mask
);

  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;

  logic                   is_byte, is_signed;
  logic [1:0][DATA_W-1:0] opnd_raw, opnd_ext;
  logic                   rel_lt, rel_gt, rel_eq;
  logic                   byte_hit;
  cond_nib_t              nib;

  assign is_byte   = mode_is_byte(mode);
  assign is_signed = mode_is_signed(mode);
  assign opnd_raw[0] = op_a;
  assign opnd_raw[1] = op_b;

  // Operand shaping: index 0 is A, index 1 is B (only B can take the immediate)
  for (genvar g = 0; g < 2; g++) begin : g_opnd
    cmpu_operand #(
      .DATA_W (DATA_W),
      .HALF_W (HALF_W),
      .IMM_W  (IMM_W)
    ) u_opnd (
      .raw       (opnd_raw[g]),
      .imm       (imm_val),
      .use_imm   ((g == 1) ? use_imm : 1'b0),
      .is_signed (is_signed),
      .wide      (wide),
      .ext       (opnd_ext[g])
    );
  end

  cmpu_relate #(.DATA_W(DATA_W)) u_relate (
    .a         (opnd_ext[0]),
    .b         (opnd_ext[1]),
    .is_signed (is_signed),
    .lt        (rel_lt),
    .gt        (rel_gt),
    .eq        (rel_eq)
  );

  cmpu_bytematch #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bytes (
    .probe (op_a[BYTE_W-1:0]),
    .pool  (op_b),
    .hit   (byte_hit)
  );

  always_comb begin
    if (is_byte) begin
      nib.lt = 1'b0;
      nib.gt = byte_hit;
      nib.eq = 1'b0;
      nib.so = 1'b0;
    end else begin
      nib.lt = rel_lt;
      nib.gt = rel_gt;
      nib.eq = rel_eq;
      nib.so = so_in;
    end
  end

  assign cond_out = nib;

  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    assign field_mask[f] = (field_sel == FIELD_W'(f));
  end

  always_comb begin
    if (!$isunknown({op_a, op_b, imm_val, use_imm, mode, wide, so_in, field_sel})) begin
      a_r8_one_relation: assert (is_byte || $countones(cond_out[NIB_LT:NIB_EQ]) == 1)
        else $error("compare did not give exactly one relation");
      a_r7_so_bit: assert (cond_out[NIB_SO] == (!is_byte && so_in))
        else $error("overflow bit wrong for mode");
      a_r6_byte_code: assert (!is_byte || cond_out == 4'h0 || cond_out == 4'h4)
        else $error("byte test produced an illegal nibble");
      a_r4_low_equal: assert (is_byte || wide || use_imm ||
                              op_a[HALF_W-1:0] != op_b[HALF_W-1:0] || cond_out[NIB_EQ])
        else $error("equal low halves not reported equal");
      a_r9_mask_onehot: assert ($countones(field_mask) == 1 && field_mask[field_sel])
        else $error("field mask not one-hot at selected index");
    end
  end

endmodule

// File: tb/test_cmpu_cond_unit.sv
module test_cmpu_cond_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [15:0] imm_val = '0;
  logic        use_imm = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        wide = 1'b1;
  logic        so_in = 1'b0;
  logic [2:0]  field_sel = '0;
  logic [3:0]  cond_out;
  logic [7:0]  field_mask;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  cmpu_cond_unit i_cmpu_cond_unit (
    .op_a(op_a), .op_b(op_b), .imm_val(imm_val), .use_imm(use_imm),
    .mode(mode), .wide(wide), .so_in(so_in), .field_sel(field_sel),
    .cond_out(cond_out), .field_mask(field_mask)
  );

  function automatic logic [63:0] corner(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'h2;
      3: return 64'hFFFF_FFFF_FFFF_FFFF;
      4: return 64'hFFFF_FFFF_FFFF_FFFE;
      5: return 64'h7FFF_FFFF_FFFF_FFFE;
      6: return 64'h7FFF_FFFF_FFFF_FFFF;
      7: return 64'h8000_0000_0000_0000;
      8: return 64'h8000_0000_0000_0001;
      9: return 64'h1234_5678_7FFF_FFFF;
      10: return 64'h1234_5678_8000_0000;
      11: return 64'hFFFF_FFFF_AAAA_AAAA;
      12: return 64'h0000_0000_AAAA_AAAA;
      default: return 64'h5555_0000_0000_0001;
    endcase
  endfunction

  function automatic logic [15:0] imm_corner(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'h8001;
      5: return 16'hFFFF;
      default: return 16'hFFFE;
    endcase
  endfunction

  // Independent model: compare as integers of the chosen signedness
  function automatic logic [3:0] model_cmp(input logic [63:0] a, input logic [63:0] b,
                                           input logic [15:0] im, input logic ui,
                                           input logic logical, input logic w,
                                           input logic so);
    logic [63:0] bsel;
    logic lt, gt, eq;
    if (ui) bsel = logical ? 64'(im) : 64'(longint'(shortint'(im)));
    else    bsel = b;
    if (logical) begin
      longint unsigned ua, ub;
      ua = w ? a : 64'(a[31:0]);
      ub = w ? bsel : 64'(bsel[31:0]);
      lt = ua < ub; gt = ua > ub; eq = ua == ub;
    end else begin
      longint sa, sb;
      sa = w ? longint'(a) : longint'(int'(a[31:0]));
      sb = w ? longint'(bsel) : longint'(int'(bsel[31:0]));
      lt = sa < sb; gt = sa > sb; eq = sa == sb;
    end
    return {lt, gt, eq, so};
  endfunction

  function automatic logic [3:0] model_byte(input logic [63:0] a, input logic [63:0] b);
    for (int i = 0; i < 8; i++)
      if (b[8*i +: 8] == a[7:0]) return 4'h4;
    return 4'h0;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h imm=%h ui=%0b mode=%0d wide=%0b so=%0b)",
               req, got, exp, op_a, op_b, imm_val, use_imm, mode, wide, so_in);
    end
  endtask

  task automatic apply;
    #2;
  endtask

  initial begin
    #400000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    apply();
    // R1 R8: all-zero signed compare reports equal only
    check("R1", 8'(cond_out), 8'h2);

    // R2 R3 R4 R7 R8: register compares over corner pairs
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int x = 0; x < 14; x++)
          for (int y = 0; y < 14; y++) begin
            @(negedge clk);
            op_a = corner(x); op_b = corner(y); use_imm = 1'b0;
            mode = 2'(m); wide = w[0]; so_in = x[0] ^ y[0];
            apply();
            check(m == 0 ? (w == 1 ? "R2" : "R4") : "R3", 8'(cond_out),
                  8'(model_cmp(op_a, op_b, imm_val, 1'b0, m[0], w[0], so_in)));
          end

    // R5: immediate operand, op_b scrambled so it must be ignored
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int x = 0; x < 14; x++)
          for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            op_a = corner(x); op_b = ~corner(x); imm_val = imm_corner(k);
            use_imm = 1'b1; mode = 2'(m); wide = w[0]; so_in = k[0];
            apply();
            check("R5", 8'(cond_out),
                  8'(model_cmp(op_a, op_b, imm_val, 1'b1, m[0], w[0], so_in)));
          end

    // R2: documented example, upper ones less than upper zeros
    @(negedge clk);
    op_a = 64'hFFFF_FFFF_AAAA_AAAA; op_b = 64'h0000_0000_AAAA_AAAA;
    use_imm = 1'b0; mode = 2'b00; wide = 1'b1; so_in = 1'b0;
    apply();
    check("R2", 8'(cond_out), 8'h8);
    // R4: same pair, narrow length makes them equal
    @(negedge clk);
    wide = 1'b0;
    apply();
    check("R4", 8'(cond_out), 8'h2);

    // R6 R7: every probe byte against several pools, other inputs toggled
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 256; v++) begin
        @(negedge clk);
        case (p)
          0: op_b = 64'h0001_0305_0709_0B0F;
          1: op_b = 64'hFFEE_DDCC_BBAA_9988;
          2: op_b = 64'h8080_8080_8080_8080;
          default: op_b = 64'h0123_4567_89AB_CDEF;
        endcase
        op_a = {56'hA5A5_A5A5_A5A5_A5, 8'(v)};
        mode = p[0] ? 2'b11 : 2'b10;
        use_imm = v[0]; imm_val = 16'(v * 37); wide = v[1]; so_in = v[2];
        apply();
        check(v[2] ? "R7" : "R6", 8'(cond_out), 8'(model_byte(op_a, op_b)));
      end

    // R9: field mask for every index across modes
    for (int f = 0; f < 8; f++) begin
      @(negedge clk);
      field_sel = 3'(f); mode = 2'(f % 3);
      apply();
      check("R9", field_mask, 8'(1 << f));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule